// File: doc/BRIEF.md
# Frame-End Interrupt Status Aggregator

This block sits beside the transfer engine of a USB host controller. The engine reports transaction outcomes as one-cycle pulses: a completion that asked for an interrupt, a short packet, a transaction error, babble and stall. Software should not see these outcomes the moment they happen. Each pulse is latched into a shadow flag. The shadow flags move into the software-visible status register only when the frame-end strobe arrives. The shadow flags are then emptied for the next frame.

Two status bits are visible. One is the general completion-interrupt bit and the other is the error-interrupt bit. An enable register decides whether a committed completion interrupt asserts the interrupt request. It has separate control over completions and short packets. The error bit always asserts the request. The request is a level that stays high until software clears the responsible status bit by writing 1 to it. A single register port selects status or enable with one address bit and reads them combinationally.

Top module: `frame_irq_aggr`

## Requirements
- R1: After reset, the status register reads 0, the enable register reads 0 and `irq` is low.
- R2: A completion pulse (`evt_ioc`) does not change the status register until the next frame-end strobe. After that strobe, status bit 0 (completion interrupt) reads 1.
- R3: A short-packet pulse sets status bit 0 at frame end. It drives `irq` only while enable bit 3 (short-packet enable) is 1.
- R4: A committed completion drives `irq` only while enable bit 2 (completion enable) is 1.
- R5: A babble pulse sets only status bit 1 (error interrupt) at frame end. Whenever status bit 1 is 1, `irq` is high, whatever the enables hold.
- R6: A transaction-error pulse or a stall pulse sets both status bit 0 and status bit 1 at frame end.
- R7: Writing to address 0 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged.
- R8: If a frame-end commit sets a status bit in the same cycle that a write clears it, the bit reads 1 afterwards.
- R9: An event pulse that arrives in the cycle of the frame-end strobe is not committed by that strobe. It is committed by the following one.
- R10: The enable register at address 1 is written with data bits 3:0 and reads them back. Higher data bits read 0. Enable bits 0 (timeout/CRC) and 1 (resume) are stored but do not affect `irq`.
- R11: `irq` stays high across later cycles and empty frames until the responsible status bit is cleared. Clearing status bit 0 also discards which completion kind set it, so a later short packet counts only under the short-packet enable.
- R12: A write to one address leaves the register at the other address unchanged. Status reads are zero above bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end | input | 1 | One-cycle end-of-frame strobe that commits the shadow flags |
| evt_ioc | input | 1 | Completion with interrupt request |
| evt_short | input | 1 | Short packet received |
| evt_xact_err | input | 1 | Transaction ended in error (timeout, CRC, error count exhausted) |
| evt_babble | input | 1 | Device babble detected |
| evt_stall | input | 1 | Stall handshake received |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sweeps every combination of the five event pulses under every enable value. It confirms that nothing shows before the strobe and that the committed bits and the request match an arithmetic model. A design that commits immediately, or that masks the error bit, fails the sweep. Dedicated sequences cover three cases. The first is a pulse in the strobe cycle, which a design without next-frame carry would either lose or commit early. The second is a clear write landing on a commit edge, which a design with the wrong priority would drop. The third is stale completion-kind memory after a clear, which would raise a request for an unenabled short packet.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  // status bit positions
  localparam int STS_W    = 2;
  localparam int ST_INT   = 0;
  localparam int ST_ERR   = 1;

  // enable bit positions
  localparam int EN_W      = 4;
  localparam int EN_TOCRC  = 0;
  localparam int EN_RESUME = 1;
  localparam int EN_IOC    = 2;
  localparam int EN_SPD    = 3;

  // event vector positions
  localparam int EVT_W     = 5;
  localparam int EV_IOC    = 0;
  localparam int EV_SHORT  = 1;
  localparam int EV_XERR   = 2;
  localparam int EV_BABBLE = 3;
  localparam int EV_STALL  = 4;

  typedef struct packed {
    logic spd_cause;
    logic ioc_cause;
    logic err;
    logic usbint;
  } commit_t;

  // Map a committed event vector onto status bits and completion-kind causes.
  function automatic commit_t map_events(input logic [EVT_W-1:0] ev);
    commit_t c;
    c.ioc_cause = ev[EV_IOC];
    c.spd_cause = ev[EV_SHORT];
    c.usbint    = ev[EV_IOC] | ev[EV_SHORT] | ev[EV_XERR] | ev[EV_STALL];
    c.err       = ev[EV_XERR] | ev[EV_BABBLE] | ev[EV_STALL];
    return c;
  endfunction

  // Request level: error bit unmasked, completion bit masked per kind.
  function automatic logic irq_eval(input logic [STS_W-1:0] sts,
                                    input logic ioc_c,
                                    input logic spd_c,
                                    input logic en_ioc,
                                    input logic en_spd);
    return sts[ST_ERR] |
           (sts[ST_INT] & ioc_c & en_ioc) |
           (sts[ST_INT] & spd_c & en_spd);
  endfunction

endpackage

// File: rtl/frame_evt_shadow.sv
module frame_evt_shadow #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_end,
  input  logic [N-1:0] evt,
  output logic [N-1:0] commit_ev
);

  logic [N-1:0] shadow_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shadow_q[i] <= 1'b0;
      else if (frame_end) shadow_q[i] <= evt[i];   // strobe-cycle pulse goes to next frame
      else                shadow_q[i] <= shadow_q[i] | evt[i];
    end
    assign commit_ev[i] = frame_end & shadow_q[i];
  end

endmodule

// File: rtl/frame_sts_reg.sv
module frame_sts_reg
  import frame_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  commit_t          commit_c,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] sts_q,
  output logic             ioc_c_q,
  output logic             spd_c_q
);

  logic [STS_W-1:0] set_mask;
  logic [STS_W-1:0] sts_d;

  always_comb begin
    set_mask         = '0;
    set_mask[ST_INT] = commit_c.usbint;
    set_mask[ST_ERR] = commit_c.err;
    sts_d            = (sts_q & ~clr_mask) | set_mask;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= '0;
      ioc_c_q <= 1'b0;
      spd_c_q <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      ioc_c_q <= (ioc_c_q & ~clr_mask[ST_INT]) | commit_c.ioc_cause;
      spd_c_q <= (spd_c_q & ~clr_mask[ST_INT]) | commit_c.spd_cause;
    end
  end

endmodule

// File: rtl/frame_irq_enable.sv
module frame_irq_enable
  import frame_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [EN_W-1:0] wdata,
  output logic [EN_W-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata;
  end

endmodule

// File: rtl/frame_irq_aggr.sv
module frame_irq_aggr
  import frame_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              evt_ioc,
  input  logic              evt_short,
  input  logic              evt_xact_err,
  input  logic              evt_babble,
  input  logic              evt_stall,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int STS_PAD = DATA_W - STS_W;
  localparam int EN_PAD  = DATA_W - EN_W;

  logic [EVT_W-1:0] evt_vec;
  logic [EVT_W-1:0] commit_ev;
  commit_t          commit_c;
  logic             commit_int;
  logic             commit_err;
  logic [STS_W-1:0] sts_clr;
  logic [STS_W-1:0] sts_q;
  logic             ioc_c_q;
  logic             spd_c_q;
  logic             en_wr;
  logic [EN_W-1:0]  en_q;
  logic             unused_wdata_hi;

  always_comb begin
    evt_vec            = '0;
    evt_vec[EV_IOC]    = evt_ioc;
    evt_vec[EV_SHORT]  = evt_short;
    evt_vec[EV_XERR]   = evt_xact_err;
    evt_vec[EV_BABBLE] = evt_babble;
    evt_vec[EV_STALL]  = evt_stall;
  end

  frame_evt_shadow #(.N(EVT_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .evt       (evt_vec),
    .commit_ev (commit_ev)
  );

  assign commit_c   = map_events(commit_ev);
  assign commit_int = commit_c.usbint;
  assign commit_err = commit_c.err;
  assign sts_clr    = (reg_wr && !reg_addr) ? reg_wdata[STS_W-1:0] : '0;
  assign en_wr      = reg_wr && reg_addr;

  frame_sts_reg u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_c (commit_c),
    .clr_mask (sts_clr),
    .sts_q    (sts_q),
    .ioc_c_q  (ioc_c_q),
    .spd_c_q  (spd_c_q)
  );

  frame_irq_enable u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (en_wr),
    .wdata (reg_wdata[EN_W-1:0]),
    .en_q  (en_q)
  );

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EN_W];

  assign reg_rdata = reg_addr ? {{EN_PAD{1'b0}}, en_q} : {{STS_PAD{1'b0}}, sts_q};
  assign irq       = irq_eval(sts_q, ioc_c_q, spd_c_q, en_q[EN_IOC], en_q[EN_SPD]);

endmodule

// File: rtl/frame_irq_chk.sv
module frame_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_addr,
  input logic       reg_wr,
  input logic [1:0] wdata_lo,
  input logic       commit_int,
  input logic       commit_err,
  input logic [1:0] sts_q,
  input logic [3:0] en_q,
  input logic       irq
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_int && !commit_err && !reg_wr) |=> $stable(sts_q));

  assert_err_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[1] |-> irq);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && wdata_lo[0] && !commit_int) |=> !sts_q[0]);

  assert_commit_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_int |=> sts_q[0]);

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != 2'b00));

  assert_en_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr) |=> $stable(en_q));

endmodule

bind frame_irq_aggr frame_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .wdata_lo   (reg_wdata[1:0]),
  .commit_int (commit_int),
  .commit_err (commit_err),
  .sts_q      (sts_q),
  .en_q       (en_q),
  .irq        (irq)
);

// File: tb/frame_irq_aggr_tb.sv
module frame_irq_aggr_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_end = 1'b0;
  logic [4:0] ev = '0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  frame_irq_aggr #(.DATA_W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .evt_ioc      (ev[0]),
    .evt_short    (ev[1]),
    .evt_xact_err (ev[2]),
    .evt_babble   (ev[3]),
    .evt_stall    (ev[4]),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq          (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [4:0] e, input logic fe);
    @(negedge clk);
    ev = e; frame_end = fe;
    @(negedge clk);
    ev = '0; frame_end = 1'b0;
  endtask

  // model: ev bits {stall,babble,xerr,short,ioc}
  function automatic logic [1:0] exp_sts(input logic [4:0] e);
    return {e[2] | e[3] | e[4], e[0] | e[1] | e[2] | e[4]};
  endfunction

  function automatic logic exp_irq(input logic [4:0] e, input logic [3:0] en);
    return e[2] | e[3] | e[4] | (e[0] & en[2]) | (e[1] & en[3]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rd(1'b0, d); chk("R1 status at reset", d, 0);
    rd(1'b1, d); chk("R1 enable at reset", d, 0);
    chk("R1 irq at reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 enable read-back and width
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R10 enable readback masked", d, 8'h0F);
    rd(1'b0, d); chk("R12 status untouched by enable write", d, 0);
    chk("R10 timeout/resume enables no irq", irq, 0);

    // Exhaustive sweep: every enable value x every event mix (R2..R6)
    for (int en = 0; en < 16; en++) begin
      wr(1'b1, 8'(en));
      for (int e = 0; e < 32; e++) begin
        wr(1'b0, 8'h03);
        pulse(5'(e), 1'b0);
        rd(1'b0, d); chk("R2 no status before frame end", d, 0);
        chk("R2 no irq before frame end", irq, 0);
        pulse(5'b0, 1'b1);
        rd(1'b0, d); chk("R2/R3/R5/R6 committed status", d, {6'b0, exp_sts(5'(e))});
        chk("R3/R4/R5 irq level", irq, exp_irq(5'(e), 4'(en)));
      end
    end
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h00);

    // R9 pulse in the strobe cycle belongs to next frame
    pulse(5'b01000, 1'b1);
    rd(1'b0, d); chk("R9 strobe-cycle event not committed", d, 0);
    pulse(5'b0, 1'b1);
    rd(1'b0, d); chk("R9 committed by following strobe", d, 2);

    // R7 partial clear
    wr(1'b0, 8'h00);
    rd(1'b0, d); chk("R7 writing zero keeps bits", d, 2);
    pulse(5'b00001, 1'b0); pulse(5'b0, 1'b1);
    rd(1'b0, d); chk("R7 both bits set", d, 3);
    wr(1'b0, 8'h02);
    rd(1'b0, d); chk("R7 only bit1 cleared", d, 1);
    rd(1'b1, d); chk("R12 enable untouched by status write", d, 0);

    // R8 clear and commit on the same edge
    wr(1'b0, 8'h03);
    pulse(5'b01000, 1'b0); pulse(5'b0, 1'b1);
    pulse(5'b00001, 1'b0);
    @(negedge clk);
    reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = 8'h03; frame_end = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; frame_end = 1'b0;
    rd(1'b0, d); chk("R8 commit beats clear", d, 1);

    // R11 persistence and cause discard
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h04);
    pulse(5'b00001, 1'b0); pulse(5'b0, 1'b1);
    chk("R4 ioc enabled irq", irq, 1);
    repeat (5) @(negedge clk);
    pulse(5'b0, 1'b1);
    chk("R11 irq persists", irq, 1);
    wr(1'b0, 8'h01);
    chk("R11 irq drops after clear", irq, 0);
    pulse(5'b00010, 1'b0); pulse(5'b0, 1'b1);
    chk("R11 short with only ioc enable", irq, 0);
    wr(1'b1, 8'h08);
    chk("R3 short enable raises irq", irq, 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule